// File: doc/BRIEF.md
# Energy Pulse Output Generator

This block converts signed energy-rate values into trains of fixed-width output pulses. The long-run pulse frequency of each train is proportional to the magnitude of the selected value. There are four channels. Channels 0 and 1 are the fast channels, carrying real and reactive energy respectively, and they advance their phase accumulators on every multiplexer frame tick. Channels 2 and 3 are auxiliary channels that advance only once every fourth frame tick. Because of this, the worst-case timing error of a single pulse equals one update period of its channel, and the average error is zero.

Each channel carries a six-bit source code that the host writes. The code routes one of three kinds of value to the accumulator:

- a per-channel rate register that the host writes;
- one of six post-processed sums;
- for the fast channels only, the compute engine's summed value.

Compute-engine values are captured at an accumulation-interval boundary and pulsed out during the interval that follows. Post-processed values pass through one additional interval stage before they reach the accumulator. Negative values are converted to their magnitude, and a per-channel direction output shows the sign. When a rate is too large for the accumulator, the channel emits exactly one pulse per update and never wraps around.

Top module: `energy_pulse_gen`

## Requirements
- R1: A synchronous reset drives every pulse and direction output low, clears all phase accumulators and sets every channel's source code to 36, the host rate register. As a result, a channel whose source was never written pulses from its host register.
- R2: A fast channel (0 = real, 1 = reactive) updates on each frame tick. Starting from a cleared accumulator with a constant magnitude m below 2^ACC_W, it produces exactly floor(n*m/2^ACC_W) pulses over n frame ticks.
- R3: Auxiliary channels 2 and 3 update only on every SLOW_DIV-th frame tick after reset, with SLOW_DIV defaulting to 4. Over n frames they produce floor((n/SLOW_DIV)*m/2^ACC_W) pulses.
- R4: When the magnitude is 2^ACC_W or more, a channel emits exactly one pulse per update. The accumulator clamps at its maximum and does not roll over.
- R5: A negative rate counts as its magnitude (the most negative value counts as 2^(DATA_W-1)). At each update, the direction output takes the value's sign bit (1 = negative). Between updates the direction output does not change.
- R6: Every pulse lasts exactly PULSE_W clock cycles (default 8). Consecutive pulses on a channel are separated by at least one low cycle, and a carry that arrives while a pulse is active is held until that pulse ends.
- R7: Source code 36 selects the host rate register. Codes 0 to 4 select post-processed sums 0 to 4, and code 34 selects post-processed sum 5.
- R8: Code 35 selects the compute-engine value on fast channels only. An auxiliary channel that receives code 35, or any channel that receives a code outside {0..4, 34, 35, 36}, keeps its previous source.
- R9: A compute-engine value present at an interval tick is used by the accumulator throughout the following interval, and later changes on the engine input have no effect until the next interval tick.
- R10: A post-processed value present at an interval tick reaches the accumulator only after the second interval tick, one interval later than compute-engine data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle strobe per multiplexer frame |
| interval_tick | input | 1 | One-cycle strobe at each accumulation-interval boundary |
| ce_sum | input | NUM_FAST x DATA_W | Compute-engine summed value for each fast channel |
| pp_sum | input | 6 x DATA_W | Post-processed sums, indexed 0 to 5 |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_is_sel | input | 1 | 1 writes the source code (cfg_data[5:0]), 0 writes the host rate |
| cfg_ch | input | clog2(NUM_FAST+NUM_SLOW) | Channel addressed by the write |
| cfg_data | input | DATA_W | Write data |
| pulse_out | output | NUM_FAST+NUM_SLOW | Pulse trains, one bit per channel |
| dir_out | output | NUM_FAST+NUM_SLOW | Sign of each channel's last accumulated value |

## Verification
The bench uses an 8-bit accumulator so that both sides of the saturation boundary can be swept. It drives magnitudes just below, at and above 2^8, plus the most negative value. A design that wraps instead of clamping would drop pulses at the top of the sweep, and a design that negates wrongly would miscount the negative channels and set a wrong direction flag.

Separate runs probe the source paths. One run checks that the compute-engine value waits one interval and the post-processed value waits two; an off-by-one pipeline shows up as early or missing pulses. Another run checks that auxiliary channels reject code 35 and that all channels reject undefined codes; a design that accepts them silences a channel that should keep pulsing from its host register. Pulse width and the quarter-rate update of the auxiliary channels are also measured, so a miscounted divider or width counter changes the observed counts.

// File: rtl/epg_pkg.sv
package epg_pkg;
   localparam int SRC_W = 6;
   localparam int PP_N  = 6;
   localparam logic [SRC_W-1:0] SRC_PP_LAST = 6'd4;
   localparam logic [SRC_W-1:0] SRC_PP_ALT  = 6'd34;
   localparam logic [SRC_W-1:0] SRC_ENGINE  = 6'd35;
   localparam logic [SRC_W-1:0] SRC_HOST    = 6'd36;

   // a code is accepted only if it names a source this channel can reach
   function automatic logic src_code_ok(input logic [SRC_W-1:0] code, input logic engine_ok);
      return (code <= SRC_PP_LAST) || (code == SRC_PP_ALT) || (code == SRC_HOST) ||
             (engine_ok && (code == SRC_ENGINE));
   endfunction
endpackage

// File: rtl/epg_src_sel.sv
module epg_src_sel
   import epg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit HAS_ENGINE = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           sel_we,
   input  logic                           rate_we,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [DATA_W-1:0]              engine_val,
   input  logic [PP_N-1:0][DATA_W-1:0]    pp_val,
   output logic [DATA_W-1:0]              rate
);
   logic [SRC_W-1:0]  code_q;
   logic [DATA_W-1:0] host_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= SRC_HOST;
         host_q <= '0;
      end else begin
         if (sel_we && src_code_ok(wr_data[SRC_W-1:0], HAS_ENGINE))
            code_q <= wr_data[SRC_W-1:0];
         if (rate_we)
            host_q <= wr_data;
      end
   end

   always_comb begin
      if (code_q == SRC_HOST)
         rate = host_q;
      else if (HAS_ENGINE && (code_q == SRC_ENGINE))
         rate = engine_val;
      else if (code_q == SRC_PP_ALT)
         rate = pp_val[PP_N-1];
      else if (code_q <= SRC_PP_LAST)
         rate = pp_val[code_q[2:0]];
      else
         rate = host_q;
   end
endmodule

// File: rtl/epg_phase_acc.sv
module epg_phase_acc #(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic [DATA_W-1:0] rate,
   output logic              carry,
   output logic              dir
);
   localparam int SUM_W = DATA_W + 1;
   localparam logic [SUM_W-1:0] FULL = SUM_W'(1) << ACC_W;

   logic [ACC_W-1:0]  acc_q;
   logic [DATA_W-1:0] mag;
   logic [SUM_W-1:0]  sum, rem;
   logic              wrap;
   logic [ACC_W-1:0]  acc_d;

   always_comb begin
      mag  = rate[DATA_W-1] ? (~rate + 1'b1) : rate;
      sum  = {{(SUM_W-ACC_W){1'b0}}, acc_q} + {1'b0, mag};
      wrap = (sum >= FULL);
      rem  = sum - FULL;
      if (!wrap)
         acc_d = sum[ACC_W-1:0];
      else if (rem >= FULL)
         acc_d = '1;            // clamp: never more than one carry per tick
      else
         acc_d = rem[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         carry <= 1'b0;
         dir   <= 1'b0;
      end else begin
         carry <= tick && wrap;
         if (tick) begin
            acc_q <= acc_d;
            dir   <= rate[DATA_W-1];
         end
      end
   end
endmodule

// File: rtl/epg_pulse_shaper.sv
module epg_pulse_shaper #(
   parameter int PULSE_W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic pulse
);
   localparam int CNT_W = $clog2(PULSE_W + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             start;

   assign start = (cnt_q == '0) && (pend_q || fire);
   assign pulse = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (start)
            cnt_q <= CNT_W'(PULSE_W);
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
         pend_q <= start ? (pend_q && fire) : (pend_q || fire);
      end
   end
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
   import epg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ACC_W    = 32,
   parameter int PULSE_W  = 8,
   parameter int NUM_FAST = 2,
   parameter int NUM_SLOW = 2,
   parameter int SLOW_DIV = 4,
   localparam int NCH  = NUM_FAST + NUM_SLOW,
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           frame_tick,
   input  logic                           interval_tick,
   input  logic [NUM_FAST-1:0][DATA_W-1:0] ce_sum,
   input  logic [PP_N-1:0][DATA_W-1:0]    pp_sum,
   input  logic                           cfg_we,
   input  logic                           cfg_is_sel,
   input  logic [CH_W-1:0]                cfg_ch,
   input  logic [DATA_W-1:0]              cfg_data,
   output logic [NCH-1:0]                 pulse_out,
   output logic [NCH-1:0]                 dir_out
);
   localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

   if (ACC_W < 2 || ACC_W > DATA_W) begin : g_bad_acc
      $error("ACC_W must lie in 2..DATA_W");
   end
   if (DATA_W < SRC_W) begin : g_bad_data
      $error("DATA_W too narrow for source codes");
   end
   if (PULSE_W < 1 || SLOW_DIV < 1 || NUM_FAST < 1 || NUM_SLOW < 0) begin : g_bad_cfg
      $error("illegal channel or pulse configuration");
   end

   // interval pipeline: engine data one interval, post-processed two
   logic [NUM_FAST-1:0][DATA_W-1:0] ce_hold_q;
   logic [PP_N-1:0][DATA_W-1:0]     pp_stage_q, pp_hold_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ce_hold_q  <= '0;
         pp_stage_q <= '0;
         pp_hold_q  <= '0;
      end else if (interval_tick) begin
         ce_hold_q  <= ce_sum;
         pp_stage_q <= pp_sum;
         pp_hold_q  <= pp_stage_q;
      end
   end

   // update strobe for the auxiliary channels
   logic slow_tick;
   if (SLOW_DIV == 1) begin : g_div_none
      assign slow_tick = frame_tick;
   end else begin : g_div
      logic [DIV_W-1:0] div_q;
      assign slow_tick = frame_tick && (div_q == DIV_W'(SLOW_DIV - 1));
      always_ff @(posedge clk) begin
         if (rst)
            div_q <= '0;
         else if (frame_tick)
            div_q <= slow_tick ? '0 : div_q + 1'b1;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam bit FAST = (i < NUM_FAST);
      logic              hit;
      logic [DATA_W-1:0] eng, rate;
      logic              tick, carry;

      assign hit = cfg_we && (cfg_ch == CH_W'(i));

      if (FAST) begin : g_fast
         assign eng  = ce_hold_q[i];
         assign tick = frame_tick;
      end else begin : g_slow
         assign eng  = '0;
         assign tick = slow_tick;
      end

      epg_src_sel #(.DATA_W(DATA_W), .HAS_ENGINE(FAST)) u_sel (
         .clk(clk), .rst(rst),
         .sel_we(hit && cfg_is_sel), .rate_we(hit && !cfg_is_sel),
         .wr_data(cfg_data), .engine_val(eng), .pp_val(pp_hold_q),
         .rate(rate)
      );

      epg_phase_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
         .clk(clk), .rst(rst), .tick(tick), .rate(rate),
         .carry(carry), .dir(dir_out[i])
      );

      epg_pulse_shaper #(.PULSE_W(PULSE_W)) u_shp (
         .clk(clk), .rst(rst), .fire(carry), .pulse(pulse_out[i])
      );
   end
endmodule

// File: rtl/epg_checker.sv
module epg_checker #(
   parameter int NCH     = 4,
   parameter int PULSE_W = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           frame_tick,
   input logic [NCH-1:0] pulse_out,
   input logic [NCH-1:0] dir_out
);
   localparam int RUN_W = $clog2(PULSE_W + 2);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pulse_out == '0 && dir_out == '0));

   assert_dir_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(frame_tick) |-> $stable(dir_out));

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      logic [RUN_W-1:0] run_q;
      always_ff @(posedge clk) begin
         if (rst)
            run_q <= '0;
         else
            run_q <= pulse_out[i] ? run_q + 1'b1 : '0;
      end

      assert_width_max_R6: assert property (@(posedge clk) disable iff (rst)
         pulse_out[i] |-> (run_q < RUN_W'(PULSE_W)));

      assert_width_exact_R6: assert property (@(posedge clk) disable iff (rst)
         $fell(pulse_out[i]) |-> (run_q == RUN_W'(PULSE_W)));

      assert_gap_R6: assert property (@(posedge clk) disable iff (rst)
         $fell(pulse_out[i]) |=> !pulse_out[i]);
   end
endmodule

bind energy_pulse_gen epg_checker #(
   .NCH(NUM_FAST + NUM_SLOW),
   .PULSE_W(PULSE_W)
) u_epg_checker (
   .clk(clk),
   .rst(rst),
   .frame_tick(frame_tick),
   .pulse_out(pulse_out),
   .dir_out(dir_out)
);

// File: tb/test_energy_pulse_gen.sv
module test_energy_pulse_gen;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam longint FULL = 256;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic frame_tick = 1'b0;
   logic interval_tick = 1'b0;
   logic [1:0][DW-1:0] ce_sum = '0;
   logic [5:0][DW-1:0] pp_sum = '0;
   logic cfg_we = 1'b0;
   logic cfg_is_sel = 1'b0;
   logic [1:0] cfg_ch = '0;
   logic [DW-1:0] cfg_data = '0;
   logic [3:0] pulse_out, dir_out;

   energy_pulse_gen #(.DATA_W(DW), .ACC_W(AW)) i_energy_pulse_gen (
      .clk(clk), .rst(rst), .frame_tick(frame_tick), .interval_tick(interval_tick),
      .ce_sum(ce_sum), .pp_sum(pp_sum), .cfg_we(cfg_we), .cfg_is_sel(cfg_is_sel),
      .cfg_ch(cfg_ch), .cfg_data(cfg_data), .pulse_out(pulse_out), .dir_out(dir_out)
   );

   always #5 clk = ~clk;

   int n_cmp = 0, n_err = 0;
   int rises [4] = '{0, 0, 0, 0};
   int runlen [4] = '{0, 0, 0, 0};
   int lastw [4] = '{0, 0, 0, 0};
   int base [4];
   logic [3:0] prev = '0;

   always @(negedge clk) begin
      for (int c = 0; c < 4; c++) begin
         if (pulse_out[c] && !prev[c]) rises[c]++;
         if (pulse_out[c]) runlen[c]++;
         else if (prev[c]) begin lastw[c] = runlen[c]; runlen[c] = 0; end
      end
      prev = pulse_out;
   end

   task automatic check(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) step();
      rst = 1'b0;
   endtask

   task automatic cfg(input int ch, input bit is_sel, input logic [DW-1:0] d);
      cfg_we = 1'b1; cfg_is_sel = is_sel; cfg_ch = 2'(ch); cfg_data = d;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic interval();
      interval_tick = 1'b1; step(); interval_tick = 1'b0; step();
   endtask

   task automatic run_frames(input int n);
      for (int f = 0; f < n; f++) begin
         frame_tick = 1'b1; step(); frame_tick = 1'b0;
         repeat (15) step();
      end
      repeat (4) step();
   endtask

   task automatic snap();
      for (int c = 0; c < 4; c++) base[c] = rises[c];
   endtask

   function automatic longint expect_p(input longint n, input longint m);
      return (m >= FULL) ? n : (n * m) / FULL;
   endfunction

   function automatic int got(input int c);
      return rises[c] - base[c];
   endfunction

   longint sweep_v [5] = '{255, 256, 257, 1000, 64'h7fffffff};

   initial begin
      do_reset();
      check("R1 reset pulse_out", pulse_out, 0);
      check("R1 reset dir_out", dir_out, 0);

      // sweep host magnitudes on all channels with the reset source selection
      for (int j = 0; j < 50; j++) begin
         longint v = (j < 45) ? j * 7 : sweep_v[j - 45];
         do_reset();
         cfg(0, 1'b0, DW'(v));
         cfg(1, 1'b0, DW'(-v));
         cfg(2, 1'b0, DW'(v));
         cfg(3, 1'b0, DW'(-v));
         snap();
         run_frames(64);
         check((v >= FULL) ? "R1 R2 R4 ch0 count" : "R1 R2 ch0 count", got(0), expect_p(64, v));
         check((v >= FULL) ? "R4 R5 ch1 count" : "R2 R5 ch1 count", got(1), expect_p(64, v));
         check((v >= FULL) ? "R3 R4 ch2 count" : "R3 ch2 count", got(2), expect_p(16, v));
         check("R3 R5 ch3 count", got(3), expect_p(16, v));
         check("R5 ch1 dir", dir_out[1], (v != 0) ? 1 : 0);
         check("R5 ch2 dir", dir_out[2], 0);
         if (got(0) > 0) check("R6 ch0 width", lastw[0], 8);
      end

      // most negative value: magnitude 2^31 saturates
      do_reset();
      cfg(1, 1'b0, 32'h8000_0000);
      snap();
      run_frames(16);
      check("R4 R5 ch1 min-neg count", got(1), 16);
      check("R5 ch1 min-neg dir", dir_out[1], 1);

      // interval latency and rejected codes
      do_reset();
      cfg(0, 1'b1, 32'd35);
      cfg(1, 1'b1, 32'd34);
      cfg(2, 1'b1, 32'd35);
      cfg(3, 1'b1, 32'd40);
      cfg(2, 1'b0, 32'd100);
      cfg(3, 1'b0, 32'd200);
      ce_sum[0] = 32'd40;
      pp_sum[5] = 32'd60;
      snap();
      run_frames(16);
      check("R9 ch0 before first interval", got(0), 0);
      check("R10 ch1 before first interval", got(1), 0);
      check("R8 ch2 rejects code 35", got(2), 1);
      check("R8 ch3 rejects code 40", got(3), 3);
      interval();
      ce_sum[0] = 32'd90;
      snap();
      run_frames(16);
      check("R9 ch0 uses captured value", got(0), 2);
      check("R10 ch1 still staged", got(1), 0);
      check("R8 ch2 window2", got(2), 2);
      check("R8 ch3 window2", got(3), 3);
      interval();
      snap();
      run_frames(16);
      check("R9 ch0 next interval value", got(0), 6);
      check("R10 ch1 after second interval", got(1), 3);

      // post-processed code map
      do_reset();
      for (int k = 0; k < 6; k++) pp_sum[k] = DW'(20 * (k + 1));
      cfg(0, 1'b1, 32'd2);
      cfg(1, 1'b1, 32'd4);
      cfg(2, 1'b1, 32'd0);
      cfg(3, 1'b1, 32'd3);
      interval();
      interval();
      snap();
      run_frames(64);
      check("R7 ch0 code 2", got(0), 15);
      check("R7 ch1 code 4", got(1), 25);
      check("R7 ch2 code 0", got(2), 1);
      check("R7 ch3 code 3", got(3), 5);
      cfg(0, 1'b1, 32'd36);
      cfg(0, 1'b0, 32'd0);
      snap();
      run_frames(16);
      check("R7 ch0 code 36 host zero", got(0), 0);
      check("R7 ch1 code 4 continues", got(1), 6);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end
endmodule